// File: doc/BRIEF.md
# Infrared Controller Interrupt Aggregator

This block gathers the event pulses of a serial infrared controller into one registered interrupt line. The controller runs in a low-speed, a medium-speed or a fast transfer mode. There are two event banks. The low-speed bank records events while the low-speed mode is selected. The shared medium/fast bank records them in either of the two faster modes. Each bank has a sticky status register, a mask register and a write-one-to-clear register. Masking keeps an event off the interrupt line, but the event is still recorded in status.

A mode register selects the transfer mode. It also holds three gate bits: one blocks the low-speed bank, one blocks the medium/fast bank, and one blocks the FIFO-receive request. A configuration register holds a two-bit receive-timeout selector for the datapath. Software reaches every register through a 16-bit word-addressed read/write port with one cycle of read latency.

The same event strobe vector feeds both banks. Two bit positions carry a mode-dependent meaning: bit 9 is a receive timeout in the low-speed mode and an abort detection in the faster modes. Bit 8 is a framing error in the low-speed mode and a CRC error in the faster modes.

Top module: `irx_irq_agg`

## Requirements
- R1: With transfer mode 00 (low speed), a pulse on evt_i sets the matching bit of the low-speed status word. The mapping is evt_i[0] to bit 7 (transmit end), evt_i[1] to bit 8 (framing/CRC error), evt_i[2] to bit 9 (timeout/abort), evt_i[3] to bit 11 (transfer-area overflow) and evt_i[4] to bit 15 (receive end). Status bits are sticky.
- R2: With transfer mode 11 (medium) or 10 (fast), events set the medium/fast status word instead. With the reserved mode 01, events are dropped and neither status word changes.
- R3: Writing a word to a clear register clears exactly those status bits of its bank that are one in the written word. The clear registers read as zero.
- R4: If an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R5: A set bit in a bank mask register keeps that event off irq_o, but the event is still recorded in status. After reset both mask registers read 16'h8B80, so all events are masked.
- R6: The mode register gates are bit 0 (low-speed bank), bit 4 (medium/fast bank) and bit 8 (fifo_rx_req_i). A set gate blocks that source. After reset all three gates are set.
- R7: irq_o is registered. One cycle after a state change it equals the OR of three terms: the low-speed bank's unmasked status (if its gate is clear), the medium/fast bank's unmasked status (if its gate is clear), and fifo_rx_req_i (if its gate is clear).
- R8: The configuration register holds the receive-timeout selector at bits 9:8, which is driven on rto_sel_o. A write carrying the value 3 in that field is ignored, and the field keeps its old value.
- R9: Word addresses are: 0 mode, 1 configuration, 2/3/4 low-speed status/mask/clear, 5/6/7 medium/fast status/mask/clear. Reads return data one cycle after the request. Unimplemented bits read as zero. Writes to the status registers have no effect.
- R10: After reset the mode register reads 16'h0111, the configuration register reads 0, both status words read 0 and irq_o is low. The mode field (bits 15:14) is driven on tmode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid one cycle after a read request |
| evt_i | input | 5 | Event strobes from the datapath, one cycle each |
| fifo_rx_req_i | input | 1 | FIFO-receive interrupt request (level) |
| irq_o | output | 1 | Merged interrupt line |
| tmode_o | output | 2 | Selected transfer mode |
| rto_sel_o | output | 2 | Receive-timeout selector |

## Verification
An event or clear write applied at clock edge k is reflected in the status registers after edge k. The interrupt line follows one edge later, at k+1. A read requested at edge k has its data on bus_rdata_o after that same edge. The bench drives every input at a falling edge. It samples read data at the next falling edge and samples irq_o one full cycle after the operation's edge, holding fifo_rx_req_i constant across that window. The expected values come from a bench-side register model that is updated once per operation.

// File: rtl/irx_irq_pkg.sv
package irx_irq_pkg;

    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 3;
    localparam int NUM_EVT     = 5;
    localparam int NUM_BANK    = 2;
    localparam int BANK_BASE   = 2;
    localparam int BANK_STRIDE = 3;

    localparam int MODE_LSB      = 14;
    localparam int GATE_SLOW_BIT = 0;
    localparam int GATE_FAST_BIT = 4;
    localparam int GATE_FIFO_BIT = 8;
    localparam int RTO_LSB       = 8;

    localparam logic [1:0] RTO_ILLEGAL = 2'b11;

    localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(1);

    typedef enum logic [1:0] {
        XM_SLOW = 2'b00,
        XM_RSVD = 2'b01,
        XM_FAST = 2'b10,
        XM_MED  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       gate_fifo;
        logic       gate_fast;
        logic       gate_slow;
    } mode_reg_t;

    localparam mode_reg_t MODE_RESET = '{mode: XM_SLOW, gate_fifo: 1'b1,
                                         gate_fast: 1'b1, gate_slow: 1'b1};

    // Bit position in the status word of compact event index idx
    function automatic int evt_pos(int idx);
        int p;
        case (idx)
            0:       p = 7;
            1:       p = 8;
            2:       p = 9;
            3:       p = 11;
            default: p = 15;
        endcase
        return p;
    endfunction

    function automatic logic [NUM_EVT-1:0] pack_evt(logic [DATA_W-1:0] w);
        logic [NUM_EVT-1:0] e;
        for (int i = 0; i < NUM_EVT; i++) e[i] = w[evt_pos(i)];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] unpack_evt(logic [NUM_EVT-1:0] e);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) w[evt_pos(i)] = e[i];
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(mode_reg_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MODE_LSB +: 2]  = m.mode;
        w[GATE_FIFO_BIT]  = m.gate_fifo;
        w[GATE_FAST_BIT]  = m.gate_fast;
        w[GATE_SLOW_BIT]  = m.gate_slow;
        return w;
    endfunction

    function automatic mode_reg_t word_to_mode(logic [DATA_W-1:0] w);
        mode_reg_t m;
        m.mode      = xfer_mode_e'(w[MODE_LSB +: 2]);
        m.gate_fifo = w[GATE_FIFO_BIT];
        m.gate_fast = w[GATE_FAST_BIT];
        m.gate_slow = w[GATE_SLOW_BIT];
        return m;
    endfunction

    // off: 0 status, 1 mask, 2 clear
    function automatic logic [ADDR_W-1:0] bank_addr(int bank, int off);
        return ADDR_W'(BANK_BASE + bank * BANK_STRIDE + off);
    endfunction

endpackage

// File: rtl/irx_evt_bank.sv
module irx_evt_bank
    import irx_irq_pkg::*;
#(
    parameter int EVT_W  = NUM_EVT,
    parameter int WORD_W = DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              mask_we_i,
    input  logic              clr_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] mask_o,
    output logic              pend_o
);

    logic [EVT_W-1:0] st_q;
    logic [EVT_W-1:0] mk_q;
    logic [EVT_W-1:0] wr_bits;
    logic [EVT_W-1:0] clr_bits;

    assign wr_bits  = EVT_W'(pack_evt(DATA_W'(wdata_i)));
    assign clr_bits = clr_we_i ? wr_bits : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
            mk_q <= '1;
        end else begin
            // a new event outranks a clear of the same bit
            st_q <= (st_q & ~clr_bits) | evt_i;
            if (mask_we_i) mk_q <= wr_bits;
        end
    end

    assign status_o = WORD_W'(unpack_evt(NUM_EVT'(st_q)));
    assign mask_o   = WORD_W'(unpack_evt(NUM_EVT'(mk_q)));
    assign pend_o   = |(st_q & ~mk_q);

endmodule

// File: rtl/irx_mode_cfg.sv
module irx_mode_cfg
    import irx_irq_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mode_we_i,
    input  logic              cfg_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output mode_reg_t         mode_o,
    output logic [1:0]        rto_o
);

    mode_reg_t  mode_q;
    logic [1:0] rto_q;
    logic [1:0] rto_wr;

    assign rto_wr = wdata_i[RTO_LSB +: 2];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= MODE_RESET;
            rto_q  <= 2'b00;
        end else begin
            if (mode_we_i) mode_q <= word_to_mode(DATA_W'(wdata_i));
            if (cfg_we_i && (rto_wr != RTO_ILLEGAL)) rto_q <= rto_wr;
        end
    end

    assign mode_o = mode_q;
    assign rto_o  = rto_q;

endmodule

// File: rtl/irx_irq_merge.sv
module irx_irq_merge #(
    parameter int N_SRC = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] gate_i,
    input  logic             fifo_req_i,
    input  logic             fifo_gate_i,
    output logic             irq_o
);

    logic irq_q;
    logic irq_d;

    assign irq_d = (|(pend_i & ~gate_i)) | (fifo_req_i & ~fifo_gate_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= 1'b0;
        else       irq_q <= irq_d;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irx_irq_agg.sv
module irx_irq_agg
    import irx_irq_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int EW    = NUM_EVT,
    parameter int BANKS = NUM_BANK
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          bus_req_i,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic [EW-1:0] evt_i,
    input  logic          fifo_rx_req_i,
    output logic          irq_o,
    output logic [1:0]    tmode_o,
    output logic [1:0]    rto_sel_o
);

    logic          wr_en;
    logic          rd_en;
    mode_reg_t     mode_q;
    logic [1:0]    rto_q;
    logic [DW-1:0] bank_st   [BANKS];
    logic [DW-1:0] bank_mk   [BANKS];
    logic [EW-1:0] bank_evt  [BANKS];
    logic [BANKS-1:0] bank_pend;
    logic [BANKS-1:0] bank_gate;
    logic [DW-1:0] rd_next;
    logic [DW-1:0] rd_q;

    assign wr_en = bus_req_i &  bus_we_i;
    assign rd_en = bus_req_i & ~bus_we_i;

    irx_mode_cfg #(.WORD_W(DW)) u_mode (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_we_i (wr_en && (bus_addr_i == AW'(ADDR_MODE))),
        .cfg_we_i  (wr_en && (bus_addr_i == AW'(ADDR_CFG))),
        .wdata_i   (bus_wdata_i),
        .mode_o    (mode_q),
        .rto_o     (rto_q)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        if (b == 0) begin : g_slow
            assign bank_evt[b]  = (mode_q.mode == XM_SLOW) ? evt_i : '0;
            assign bank_gate[b] = mode_q.gate_slow;
        end else begin : g_fast
            assign bank_evt[b]  = ((mode_q.mode == XM_FAST) || (mode_q.mode == XM_MED))
                                  ? evt_i : '0;
            assign bank_gate[b] = mode_q.gate_fast;
        end

        irx_evt_bank #(.EVT_W(EW), .WORD_W(DW)) u_bank (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .evt_i     (bank_evt[b]),
            .mask_we_i (wr_en && (bus_addr_i == AW'(bank_addr(b, 1)))),
            .clr_we_i  (wr_en && (bus_addr_i == AW'(bank_addr(b, 2)))),
            .wdata_i   (bus_wdata_i),
            .status_o  (bank_st[b]),
            .mask_o    (bank_mk[b]),
            .pend_o    (bank_pend[b])
        );
    end

    irx_irq_merge #(.N_SRC(BANKS)) u_merge (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pend_i      (bank_pend),
        .gate_i      (bank_gate),
        .fifo_req_i  (fifo_rx_req_i),
        .fifo_gate_i (mode_q.gate_fifo),
        .irq_o       (irq_o)
    );

    always_comb begin
        rd_next = '0;
        if (bus_addr_i == AW'(ADDR_MODE)) rd_next = DW'(mode_to_word(mode_q));
        if (bus_addr_i == AW'(ADDR_CFG))  rd_next[RTO_LSB +: 2] = rto_q;
        for (int b = 0; b < BANKS; b++) begin
            if (bus_addr_i == AW'(bank_addr(b, 0))) rd_next = bank_st[b];
            if (bus_addr_i == AW'(bank_addr(b, 1))) rd_next = bank_mk[b];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)      rd_q <= '0;
        else if (rd_en) rd_q <= rd_next;
    end

    assign bus_rdata_o = rd_q;
    assign tmode_o     = mode_q.mode;
    assign rto_sel_o   = rto_q;

endmodule

// File: rtl/irx_irq_agg_chk.sv
module irx_irq_agg_chk
    import irx_irq_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input logic        bus_req_i,
    input logic        bus_we_i,
    input logic [2:0]  bus_addr_i,
    input logic [15:0] bus_wdata_i,
    input logic [15:0] bus_rdata_o,
    input logic [4:0]  evt_i,
    input logic        irq_o,
    input logic [1:0]  cur_mode,
    input logic [2:0]  gates,
    input logic [1:0]  rto_val,
    input logic [15:0] slow_st,
    input logic [15:0] fast_st,
    input logic [15:0] slow_mk,
    input logic [15:0] fast_mk
);

    logic wr;
    assign wr = bus_req_i && bus_we_i;

    p_evt_slow_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == 2'b00 && |evt_i) |=> ((pack_evt(slow_st) & $past(evt_i)) == $past(evt_i)));

    p_evt_fast_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode[1] && |evt_i) |=> ((pack_evt(fast_st) & $past(evt_i)) == $past(evt_i)));

    p_rsvd_drop_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == 2'b01 && !wr) |=> ($stable(slow_st) && $stable(fast_st)));

    p_clear_exact_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr && bus_addr_i == 3'd4 && evt_i == '0)
        |=> ((pack_evt(slow_st) & pack_evt($past(bus_wdata_i))) == '0));

    p_clear_reads_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_req_i && !bus_we_i && (bus_addr_i == 3'd4 || bus_addr_i == 3'd7))
        |=> (bus_rdata_o == 16'h0000));

    p_event_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr && bus_addr_i == 3'd4 && cur_mode == 2'b00 && |(evt_i & pack_evt(bus_wdata_i)))
        |=> ((pack_evt(slow_st) & $past(evt_i)) == $past(evt_i)));

    p_all_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (slow_mk == 16'h8B80 && fast_mk == 16'h8B80 && gates[2]) |=> !irq_o);

    p_all_gated_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (gates == 3'b111) |=> !irq_o);

    p_rto_legal_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        rto_val != 2'b11);

    p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rdata_o & ~16'hCB91) == 16'h0000);

endmodule

bind irx_irq_agg irx_irq_agg_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .evt_i       (evt_i),
    .irq_o       (irq_o),
    .cur_mode    (tmode_o),
    .gates       ({mode_q.gate_fifo, mode_q.gate_fast, mode_q.gate_slow}),
    .rto_val     (rto_sel_o),
    .slow_st     (bank_st[0]),
    .fast_st     (bank_st[1]),
    .slow_mk     (bank_mk[0]),
    .fast_mk     (bank_mk[1])
);

// File: tb/test_irx_irq_agg.sv
`timescale 1ns/1ps
module test_irx_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  evt = '0;
    logic        fifo = 1'b0;
    logic        irq;
    logic [1:0]  tmode;
    logic [1:0]  rto;

    int n_chk  = 0;
    int n_fail = 0;

    // bench-side register model
    logic [1:0] m_mode;
    logic       m_g0, m_g4, m_g8;
    logic [1:0] m_rto;
    logic [4:0] m_st [2];
    logic [4:0] m_mk [2];

    always #2 clk = ~clk;

    irx_irq_agg i_irx_irq_agg (
        .clk_i(clk), .rst_i(rst), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .evt_i(evt), .fifo_rx_req_i(fifo), .irq_o(irq),
        .tmode_o(tmode), .rto_sel_o(rto)
    );

    function automatic logic [4:0] w2e(logic [15:0] w);
        return {w[15], w[11], w[9], w[8], w[7]};
    endfunction

    function automatic logic [15:0] e2w(logic [4:0] e);
        return {e[4], 3'b000, e[3], 1'b0, e[2], e[1], e[0], 7'b0000000};
    endfunction

    function automatic logic exp_irq();
        return ((|(m_st[0] & ~m_mk[0])) & ~m_g0) |
               ((|(m_st[1] & ~m_mk[1])) & ~m_g4) | (fifo & ~m_g8);
    endfunction

    function automatic logic [15:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return {m_mode, 5'b0, m_g8, 3'b0, m_g4, 3'b0, m_g0};
            3'd1: return {6'b0, m_rto, 8'b0};
            3'd2: return e2w(m_st[0]);
            3'd3: return e2w(m_mk[0]);
            3'd5: return e2w(m_st[1]);
            3'd6: return e2w(m_mk[1]);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 2'b00; m_g0 = 1'b1; m_g4 = 1'b1; m_g8 = 1'b1; m_rto = 2'b00;
        for (int b = 0; b < 2; b++) begin m_st[b] = '0; m_mk[b] = '1; end
    endtask

    // One cycle with optional write and events; model updated, irq checked a cycle later
    task automatic op(logic do_wr, logic [2:0] a, logic [15:0] d, logic [4:0] e, string tag);
        int bk;
        @(negedge clk);
        req = do_wr; we = do_wr; addr = a; wdata = d; evt = e;
        @(negedge clk);
        req = 1'b0; we = 1'b0; evt = '0;
        bk = (m_mode == 2'b00) ? 0 : (m_mode[1] ? 1 : -1);
        if (do_wr && a == 3'd4) m_st[0] = m_st[0] & ~w2e(d);
        if (do_wr && a == 3'd7) m_st[1] = m_st[1] & ~w2e(d);
        if (bk >= 0) m_st[bk] = m_st[bk] | e;
        if (do_wr && a == 3'd3) m_mk[0] = w2e(d);
        if (do_wr && a == 3'd6) m_mk[1] = w2e(d);
        if (do_wr && a == 3'd1 && d[9:8] != 2'b11) m_rto = d[9:8];
        if (do_wr && a == 3'd0) begin
            m_mode = d[15:14]; m_g8 = d[8]; m_g4 = d[4]; m_g0 = d[0];
        end
        @(negedge clk);
        check({tag, " R7 irq"}, {15'b0, irq}, {15'b0, exp_irq()});
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        check({tag, " R9 read"}, rdata, exp_read(a));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset values, R5 mask reset
        @(negedge clk);
        check("R10 irq after reset", {15'b0, irq}, 16'h0);
        rd(3'd0, "R10 mode reset");
        check("R10 mode reset value", rdata, 16'h0111);
        rd(3'd1, "R10 cfg reset");
        rd(3'd2, "R10 slow status reset");
        rd(3'd3, "R5 slow mask reset");
        check("R5 mask reset value", rdata, 16'h8B80);
        rd(3'd6, "R5 fast mask reset");

        // R1 routing in low-speed mode, all masked: status set, irq low (R5)
        op(1'b0, 3'd0, 16'h0, 5'b10101, "R1 R5 masked event");
        rd(3'd2, "R1 slow status");
        check("R1 bit positions", rdata, 16'h8280);
        rd(3'd5, "R1 fast untouched");

        // R6: unmask but keep gate, then open gate
        op(1'b1, 3'd3, 16'h0000, 5'b0, "R6 unmask gated");
        check("R6 gated irq low", {15'b0, irq}, 16'h0);
        op(1'b1, 3'd0, 16'h0110, 5'b0, "R6 open slow gate");
        check("R7 irq high", {15'b0, irq}, 16'h1);
        rd(3'd0, "R9 mode readback");

        // R3 partial clear, R4 event beats clear
        op(1'b1, 3'd4, 16'h8000, 5'b0, "R3 clear bit15");
        rd(3'd2, "R3 after partial clear");
        check("R3 exact clear", rdata, 16'h0280);
        op(1'b1, 3'd4, 16'hFFFF, 5'b00010, "R4 event vs clear");
        rd(3'd2, "R4 status");
        check("R4 event wins", rdata, 16'h0100);
        rd(3'd4, "R3 clear reads zero");
        op(1'b1, 3'd2, 16'hFFFF, 5'b0, "R9 status write ignored");
        rd(3'd2, "R9 status unchanged");

        // R2 fast and medium modes, reserved mode
        op(1'b1, 3'd0, 16'h8000, 5'b0, "R2 fast mode");
        check("R10 tmode port", {14'b0, tmode}, 16'h0002);
        op(1'b0, 3'd0, 16'h0, 5'b01000, "R2 fast event");
        op(1'b1, 3'd0, 16'hC000, 5'b0, "R2 medium mode");
        op(1'b0, 3'd0, 16'h0, 5'b00100, "R2 medium event");
        rd(3'd5, "R2 fast status");
        check("R2 fast bank bits", rdata, 16'h0A00);
        op(1'b1, 3'd0, 16'h4000, 5'b0, "R2 reserved mode");
        op(1'b0, 3'd0, 16'h0, 5'b11111, "R2 reserved drop");
        rd(3'd2, "R2 slow after reserved");
        rd(3'd5, "R2 fast after reserved");

        // R8 timeout field
        op(1'b1, 3'd1, 16'hFEFF, 5'b0, "R8 write 2");
        check("R8 rto port", {14'b0, rto}, 16'h0002);
        op(1'b1, 3'd1, 16'h0300, 5'b0, "R8 write 3 ignored");
        check("R8 illegal ignored", {14'b0, rto}, 16'h0002);
        rd(3'd1, "R8 cfg readback");

        // R6 fifo gate
        fifo = 1'b1;
        op(1'b1, 3'd0, 16'h0011, 5'b0, "R6 fifo open");
        op(1'b1, 3'd0, 16'h0111, 5'b0, "R6 fifo gated");
        fifo = 1'b0;

        // random phase
        for (int it = 0; it < 600; it++) begin
            int k;
            k = $urandom % 8;
            case (k)
                0, 1, 2: op(1'b0, 3'd0, 16'h0, 5'($urandom), "R1 R2 rnd event");
                3: op(1'b1, 3'($urandom), 16'($urandom), 5'b0, "R9 rnd write");
                4: op(1'b1, (($urandom % 2) == 0) ? 3'd4 : 3'd7, 16'($urandom),
                      5'($urandom), "R3 R4 rnd clear");
                5: rd(3'($urandom), "R9 rnd");
                6: begin fifo = 1'($urandom); op(1'b0, 3'd0, 16'h0, 5'b0, "R6 rnd fifo"); end
                default: op(1'b1, 3'd0, 16'($urandom) & 16'hC111, 5'b0, "R6 rnd mode");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule